// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a four-beat burst. When a load is accepted it captures a full starting address. On each later cycle with an advance request, it steps the two lowest address bits to the next beat. The bits above those two are never touched between loads, so every beat stays inside the aligned four-word block that the starting address belongs to.

A static mode input picks the beat order. In interleaved order, each beat address is the starting low bits XORed with the beat count. In linear order, it is the starting low bits plus the beat count, modulo four. The beat count and a last-beat flag are also brought out, so that a controller or a bench can follow the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `addr` is 0, `beat` is 0 and `last_beat` is 0.
- R2: A clock edge with `load` high captures the whole of `load_addr` into `addr` and sets `beat` to 0. The value of `adv` on that edge has no effect.
- R3: Bits `addr[AW-1:2]` keep their loaded value on every edge where `load` is low.
- R4: With `interleave` = 1, `addr[1:0]` equals the loaded low bits XOR `beat`. For example, a start of 01 gives the order 01, 00, 11, 10.
- R5: With `interleave` = 0, `addr[1:0]` equals the loaded low bits plus `beat`, modulo 4. For example, a start of 01 gives the order 01, 10, 11, 00.
- R6: On an edge with `load` = 0 and `adv` = 1, `beat` increases by one. On an edge with `load` = 0 and `adv` = 0, both `beat` and `addr` hold.
- R7: After beat 3, the next advance returns `beat` to 0, so the sequence repeats within the same four-word block. `last_beat` is 1 exactly when `beat` is 3.
- R8: A load in the middle of a burst restarts the sequence at beat 0 from the newly loaded address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Accepts a new starting address; takes priority over advance |
| load_addr | input | AW | Starting address captured on a load |
| adv | input | 1 | Advance request; steps the burst when no load is present |
| interleave | input | 1 | Static order select: 1 for XOR order, 0 for linear order |
| addr | output | AW | Current beat address |
| beat | output | 2 | Beats taken since the last load, modulo 4 |
| last_beat | output | 1 | High while the fourth beat is presented |

## Verification
A load and an advance request can arrive on the same edge. This happens both at the start of a burst and partway through one. In that case the load must win and the advance must leave no trace. The bench provokes this by holding `adv` high during loads, including a reload two beats into a running burst. It then judges the result by expecting beat 0 and the exact new address on the next cycle, followed by the first step on the edge after that. The wrap from beat 3 back to 0 under a continuous advance is checked the same way, in both orders.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          adv,
  input  logic          interleave,
  output logic [AW-1:0] addr,
  output logic [1:0]    beat,
  output logic          last_beat
);
  localparam int HW = AW - 2;

  logic [HW-1:0] base_q;
  logic [1:0]    start_q;
  logic [1:0]    cnt_q;
  logic [1:0]    low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      base_q  <= load_addr[AW-1:2];
      start_q <= load_addr[1:0];
      cnt_q   <= '0;
    end else if (adv) begin
      cnt_q   <= cnt_q + 2'd1;
    end
  end

  assign low       = interleave ? (start_q ^ cnt_q) : (start_q + cnt_q);
  assign addr      = {base_q, low};
  assign beat      = cnt_q;
  assign last_beat = (cnt_q == 2'd3);
endmodule

module burst_addr_seq_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [AW-1:0] load_addr,
  input logic          adv,
  input logic          interleave,
  input logic [AW-1:0] addr,
  input logic [1:0]    beat,
  input logic          last_beat
);
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_state: assert (addr == '0 && beat == 2'd0 && !last_beat);
    end
  end

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(load_addr) || interleave != $past(interleave)) && beat == 2'd0);

  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr[AW-1:2] == $past(addr[AW-1:2]));

  a_r4_xor_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && interleave) |=> (!interleave ||
      ((addr[1:0] ^ $past(addr[1:0])) == (beat ^ $past(beat)))));

  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && !interleave) |=> (interleave ||
      (addr[1:0] == $past(addr[1:0]) + 2'd1)));

  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> beat == $past(beat) + 2'd1);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(beat) && (interleave != $past(interleave) || $stable(addr)));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && adv && !load) |=> beat == 2'd0 && !last_beat);

  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (load && beat != 2'd0) |=> beat == 2'd0);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) chk_i (.*);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic          adv = 1'b0;
  logic          interleave = 1'b1;
  logic [AW-1:0] addr;
  logic [1:0]    beat;
  logic          last_beat;

  burst_addr_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr), .adv(adv),
    .interleave(interleave), .addr(addr), .beat(beat), .last_beat(last_beat)
  );

  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [AW-1:0] qa[$];
  logic [1:0]    qb[$];
  logic          ql[$];
  string         qt[$];

  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_cnt = '0;

  task automatic cmp(input string tag, input logic [AW-1:0] ea, input logic [1:0] eb, input logic el);
    n_vec++;
    if (addr !== ea || beat !== eb || last_beat !== el) begin
      n_bad++;
      $display("FAIL %s: addr=%h beat=%0d last=%0b expected addr=%h beat=%0d last=%0b",
               tag, addr, beat, last_beat, ea, eb, el);
    end
  endtask

  task automatic cyc(input logic ld, input logic [AW-1:0] la, input logic ad,
                     input logic il, input string tag);
    logic [1:0] lo;
    @(negedge clk);
    #2;
    load = ld; load_addr = la; adv = ad; interleave = il;
    @(posedge clk);
    if (ld) begin
      m_base = la[AW-1:2]; m_start = la[1:0]; m_cnt = 2'd0;
    end else if (ad) begin
      m_cnt = m_cnt + 2'd1;
    end
    lo = il ? (m_start ^ m_cnt) : (m_start + m_cnt);
    qa.push_back({m_base, lo});
    qb.push_back(m_cnt);
    ql.push_back(m_cnt == 2'd3);
    qt.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (qa.size() > 0) cmp(qt.pop_front(), qa.pop_front(), qb.pop_front(), ql.pop_front());
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    cmp("R1 in reset", '0, 2'd0, 1'b0);
    #2 rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after release", '0, 2'd0, 1'b0);

    cyc(1'b1, 17'h1ABC5, 1'b1, 1'b1, "R2 load with adv high");
    cyc(1'b0, '0, 1'b1, 1'b1, "R4 beat1");
    cyc(1'b0, '0, 1'b1, 1'b1, "R4 beat2");
    cyc(1'b0, '0, 1'b0, 1'b1, "R6 hold");
    cyc(1'b0, '0, 1'b0, 1'b1, "R6 hold again");
    cyc(1'b0, 17'h0FFFF, 1'b1, 1'b1, "R4 beat3 last R7");
    cyc(1'b0, '0, 1'b1, 1'b1, "R7 wrap to beat0");
    cyc(1'b0, '0, 1'b1, 1'b1, "R3 upper kept");

    cyc(1'b1, 17'h00402, 1'b0, 1'b1, "R2 load start 10");
    for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1, 1'b1, "R4 xor from 10");

    cyc(1'b1, 17'h12341, 1'b1, 1'b0, "R2 linear load");
    for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1, 1'b0, "R5 linear from 01");
    cyc(1'b0, '0, 1'b0, 1'b0, "R6 linear hold");

    cyc(1'b1, 17'h00013, 1'b0, 1'b0, "R2 linear start 11");
    cyc(1'b0, '0, 1'b1, 1'b0, "R5 beat1");
    cyc(1'b0, '0, 1'b1, 1'b0, "R5 beat2");
    cyc(1'b1, 17'h1FFFE, 1'b1, 1'b0, "R8 reload mid burst");
    cyc(1'b0, '0, 1'b1, 1'b0, "R8 first step after reload");
    cyc(1'b0, '0, 1'b1, 1'b0, "R5 wraps inside block");
    cyc(1'b0, '0, 1'b1, 1'b0, "R3 upper kept linear");

    cyc(1'b1, 17'h0AAA7, 1'b1, 1'b1, "R8 reload interleaved");
    for (int i = 0; i < 4; i++) cyc(1'b0, '0, 1'b1, 1'b1, "R4 xor from 11");

    @(negedge clk);
    #2 load = 1'b0; adv = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule